// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block sits between eight shared external interrupt pins plus one non-maskable interrupt pin and the chip's interrupt priority logic. Each group of four pins serves either as four separate active-low request lines or as one 4-bit encoded priority level. A per-group select input chooses the use, and the path not chosen is held at its idle value so that pin activity cannot leak into it. All pins pass through a two-flop synchronizer. Level-sensed request lines and the encoded level then pass through a noise canceller. This canceller accepts a new value only after that value has been held for `STABLE` consecutive synchronized samples.

A hold-mode input sets how level requests are presented. In latched mode a detected request is stored until software clears it by a write-one-to-clear pulse. In transparent mode the outputs follow the filtered pins. Request lines set to edge sense are always stored on a falling edge. A per-group mask stops new encoded-level requests. It does not cancel a level that is already stored. A separate detector turns a falling edge on the non-maskable pin into a request that stays set until it is acknowledged. All of the block's pins are plain control and status signals, so no valid/ready handshake applies.

Top module: `eic_top`

## Requirements
- R1: While reset is asserted, and at the first clock after it is released, `irq_pend`, `irl_level` and `nmi_req` are all zero.
- R2: When `grp_irq_mode[g]` is 1, pins 4g..4g+3 feed the request lines and group g's encoded level is held at "no request". When it is 0, those four request lines see an idle (high) input and the pins feed the encoded level.
- R3: A level-sensed request line or an encoded level changes only after the new synchronized pin value has been held for STABLE (default 3) consecutive clocks. A pin change made just after an edge shows at a transparent output after the fifth following edge, not the fourth. Shorter pulses are ignored.
- R4: On a line with `irq_edge[i]`=1, a falling edge of the synchronized pin (unfiltered) sets `irq_pend[i]` whatever `hold_off` is. The bit stays set until a clear pulse with `clr_bits[i]`=1. A new edge in the same cycle as the clear wins.
- R5: On a level-sensed line with `hold_off`=0, a filtered low sets `irq_pend[i]`. The bit stays set after the pin returns high, until a clear of `clr_bits[i]`. If the pin is still low, the bit sets again.
- R6: On a level-sensed line with `hold_off`=1, `irq_pend[i]` equals the filtered active level, and a clear pulse has no effect.
- R7: The level of group g is the bitwise inverse of its 4-bit pin code, with pin 4g as the least significant bit. An all-ones code gives level 0, which means no request.
- R8: With `hold_off`=0, a nonzero level is stored when the store is empty and `irl_mask[g]`=0. The stored value stays on `irl_level[4g+:4]` until a clear pulse with `clr_bits[8+g]`=1. The clear takes priority in its own cycle, and a level still present is stored again on the next cycle.
- R9: With `hold_off`=0, setting `irl_mask[g]` after a level is stored leaves `irl_level` unchanged. A level that appears while the mask is set is not stored.
- R10: With `hold_off`=1, `irl_level[4g+:4]` is the filtered level, or 0 while `irl_mask[g]`=1.
- R11: A falling edge of the synchronized `nmi_n` sets `nmi_req`. It stays set until `nmi_ack`, and an edge in the same cycle as the acknowledge wins. A pin held low does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_n | input | 8 | Shared interrupt pins, active low, asynchronous |
| nmi_n | input | 1 | Non-maskable interrupt pin, active low, asynchronous |
| grp_irq_mode | input | 2 | Per group: 1 = request lines, 0 = encoded level |
| irq_edge | input | 8 | Per line: 1 = falling-edge sense, 0 = level sense |
| hold_off | input | 1 | 0 = latched requests, 1 = transparent level requests |
| irl_mask | input | 2 | Per group: block storing/presenting new encoded levels |
| clr_we | input | 1 | Clear pulse strobe |
| clr_bits | input | 10 | Write-one-to-clear: bits 7..0 request lines, 9..8 group levels |
| nmi_ack | input | 1 | Clears the NMI request |
| irq_pend | output | 8 | Pending request per line |
| irl_level | output | 8 | Encoded level per group, 4 bits each, 0 = none |
| nmi_req | output | 1 | NMI request |

## Verification
The filter assertion assumes `STABLE` is at least 3, so that a filtered value can change only after two earlier samples agree with it. The stored-request assertions allow `hold_off`, `irq_edge` and the clear inputs to change at any clock. They therefore place no limits on the configuration inputs. The bench changes every input one step after a rising edge and never near the sampling point. In its random phase the pins toggle rarely enough that the noise canceller sees runs long enough to pass. Mode, hold, mask, clear and acknowledge changes are mixed in at random.

// File: rtl/eic_pkg.sv
package eic_pkg;
  // Use of a pin group
  typedef enum logic {
    SRC_LVL = 1'b0,   // group feeds encoded priority level
    SRC_REQ = 1'b1    // group feeds individual request lines
  } grp_src_e;

  localparam int DEF_STABLE = 3;   // samples a new value must persist
  localparam int SYNC_DEPTH = 2;   // synchronizer flops
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int W = 1,
  parameter int DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) stage[k] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/eic_filter.sv
// Noise canceller: output moves to a new value once that value has been
// seen for STABLE consecutive clocks (STABLE >= 2).
module eic_filter #(
  parameter int W = 1,
  parameter int STABLE = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = $clog2(STABLE + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [W-1:0]  q_r;
  logic [W-1:0]  cand;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r  <= RST_VAL;
      cand <= RST_VAL;
      run  <= '0;
    end else if (d == q_r) begin
      run <= '0;
    end else if (run != '0 && d == cand) begin
      if (run == LAST) begin
        q_r <= d;
        run <= '0;
      end else begin
        run <= run + ONE;
      end
    end else begin
      cand <= d;
      run  <= ONE;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/eic_irq_lane.sv
module eic_irq_lane #(
  parameter int STABLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,      // synchronized, gated, active low
  input  logic edge_mode,
  input  logic hold_off,
  input  logic clr,
  output logic pend_o
);
  logic filt_n;
  logic prev_n;
  logic pend;
  logic fall;

  eic_filter #(.W(1), .STABLE(STABLE), .RST_VAL(1'b1)) u_flt (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_n),
    .q    (filt_n)
  );

  assign fall = prev_n & ~raw_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_n <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_n <= raw_n;
      if (edge_mode) begin
        if (fall)     pend <= 1'b1;
        else if (clr) pend <= 1'b0;
      end else if (hold_off) begin
        pend <= 1'b0;
      end else if (!filt_n) begin
        pend <= 1'b1;
      end else if (clr) begin
        pend <= 1'b0;
      end
    end
  end

  assign pend_o = (edge_mode || !hold_off) ? pend : ~filt_n;
endmodule

// File: rtl/eic_irl_path.sv
module eic_irl_path #(
  parameter int W = 4,
  parameter int STABLE = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] code_n,   // synchronized, gated pin code
  input  logic         hold_off,
  input  logic         mask,
  input  logic         clr,
  output logic [W-1:0] filt_o,
  output logic [W-1:0] level_o
);
  logic [W-1:0] filt;
  logic [W-1:0] lvl;
  logic [W-1:0] held;

  eic_filter #(.W(W), .STABLE(STABLE), .RST_VAL({W{1'b1}})) u_flt (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (code_n),
    .q    (filt)
  );

  assign lvl = ~filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              held <= '0;
    else if (hold_off)                       held <= '0;
    else if (clr)                            held <= '0;
    else if (held == '0 && lvl != '0 && !mask) held <= lvl;
  end

  assign filt_o  = filt;
  assign level_o = hold_off ? (mask ? '0 : lvl) : held;
endmodule

// File: rtl/eic_nmi_det.sv
module eic_nmi_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s_n,
  input  logic ack,
  output logic req
);
  logic prev_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_n <= 1'b1;
      req    <= 1'b0;
    end else begin
      prev_n <= pin_s_n;
      if (prev_n && !pin_s_n) req <= 1'b1;
      else if (ack)           req <= 1'b0;
    end
  end
endmodule

// File: rtl/eic_top.sv
module eic_top
  import eic_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int GRP    = 4,
  parameter int STABLE = DEF_STABLE
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PINS-1:0]         pin_n,
  input  logic                    nmi_n,
  input  logic [PINS/GRP-1:0]     grp_irq_mode,
  input  logic [PINS-1:0]         irq_edge,
  input  logic                    hold_off,
  input  logic [PINS/GRP-1:0]     irl_mask,
  input  logic                    clr_we,
  input  logic [PINS+PINS/GRP-1:0] clr_bits,
  input  logic                    nmi_ack,
  output logic [PINS-1:0]         irq_pend,
  output logic [PINS-1:0]         irl_level,
  output logic                    nmi_req
);
  localparam int NGRP = PINS / GRP;
  localparam int SW   = PINS + 1;

  logic [SW-1:0]   sync_q;
  logic [PINS-1:0] pin_s;
  logic            nmi_s;
  logic [PINS-1:0] irq_src;
  logic [PINS-1:0] irl_src;
  logic [PINS-1:0] irl_filt;
  logic [PINS-1:0] clr_req;
  logic [NGRP-1:0] clr_lvl;

  eic_sync #(.W(SW), .DEPTH(SYNC_DEPTH), .RST_VAL({SW{1'b1}})) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({nmi_n, pin_n}),
    .q    (sync_q)
  );

  assign pin_s   = sync_q[PINS-1:0];
  assign nmi_s   = sync_q[PINS];
  assign clr_req = clr_we ? clr_bits[PINS-1:0] : '0;
  assign clr_lvl = clr_we ? clr_bits[PINS+NGRP-1:PINS] : '0;

  // Path gating: the unused use of a group sees idle (all ones) input
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic use_req;
    assign use_req = (grp_src_e'(grp_irq_mode[g]) == SRC_REQ);
    assign irq_src[g*GRP +: GRP] = use_req ? pin_s[g*GRP +: GRP] : {GRP{1'b1}};
    assign irl_src[g*GRP +: GRP] = use_req ? {GRP{1'b1}} : pin_s[g*GRP +: GRP];

    eic_irl_path #(.W(GRP), .STABLE(STABLE)) u_irl (
      .clk     (clk),
      .rst_n   (rst_n),
      .code_n  (irl_src[g*GRP +: GRP]),
      .hold_off(hold_off),
      .mask    (irl_mask[g]),
      .clr     (clr_lvl[g]),
      .filt_o  (irl_filt[g*GRP +: GRP]),
      .level_o (irl_level[g*GRP +: GRP])
    );
  end

  for (genvar i = 0; i < PINS; i++) begin : g_line
    eic_irq_lane #(.STABLE(STABLE)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_n    (irq_src[i]),
      .edge_mode(irq_edge[i]),
      .hold_off (hold_off),
      .clr      (clr_req[i]),
      .pend_o   (irq_pend[i])
    );
  end

  eic_nmi_det u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_s_n(nmi_s),
    .ack    (nmi_ack),
    .req    (nmi_req)
  );
endmodule

// File: rtl/eic_chk.sv
module eic_chk #(
  parameter int PINS = 8,
  parameter int GRP  = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [PINS-1:0]          irq_edge,
  input logic                     hold_off,
  input logic                     clr_we,
  input logic [PINS+PINS/GRP-1:0] clr_bits,
  input logic                     nmi_ack,
  input logic [PINS-1:0]          irq_pend,
  input logic [PINS-1:0]          irl_level,
  input logic                     nmi_req,
  input logic [PINS-1:0]          irl_src,
  input logic [PINS-1:0]          irl_filt
);
  localparam int NGRP = PINS / GRP;

  logic [PINS-1:0] sticky;
  assign sticky = irq_pend & irq_edge & ~(clr_we ? clr_bits[PINS-1:0] : '0);

  // R11
  nmi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req && !nmi_ack |=> nmi_req);

  // R4
  edge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sticky != '0 |=> (($past(sticky) & irq_edge & ~irq_pend) == '0));

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    // R8
    lvl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_off && irl_level[g*GRP +: GRP] != '0 && !(clr_we && clr_bits[PINS+g]))
      |=> (hold_off || $stable(irl_level[g*GRP +: GRP])));

    // R3 (valid for STABLE >= 3)
    flt_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(irl_filt[g*GRP +: GRP]) |->
        ($past(irl_src[g*GRP +: GRP]) == irl_filt[g*GRP +: GRP] &&
         $past(irl_src[g*GRP +: GRP], 2) == irl_filt[g*GRP +: GRP]));
  end
endmodule

bind eic_top eic_chk #(.PINS(PINS), .GRP(GRP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_edge (irq_edge),
  .hold_off (hold_off),
  .clr_we   (clr_we),
  .clr_bits (clr_bits),
  .nmi_ack  (nmi_ack),
  .irq_pend (irq_pend),
  .irl_level(irl_level),
  .nmi_req  (nmi_req),
  .irl_src  (irl_src),
  .irl_filt (irl_filt)
);

// File: tb/test_eic_top.sv
`timescale 1ns/1ps
module test_eic_top;
  localparam int PINS = 8, GRP = 4, NG = 2, STABLE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] pin_n = '1;
  logic       nmi_n = 1'b1;
  logic [1:0] grp_irq_mode = '0;
  logic [7:0] irq_edge = '0;
  logic       hold_off = 1'b0;
  logic [1:0] irl_mask = '0;
  logic       clr_we = 1'b0;
  logic [9:0] clr_bits = '0;
  logic       nmi_ack = 1'b0;
  logic [7:0] irq_pend;
  logic [7:0] irl_level;
  logic       nmi_req;

  eic_top #(.PINS(PINS), .GRP(GRP), .STABLE(STABLE)) i_eic_top (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .nmi_n(nmi_n),
    .grp_irq_mode(grp_irq_mode), .irq_edge(irq_edge), .hold_off(hold_off),
    .irl_mask(irl_mask), .clr_we(clr_we), .clr_bits(clr_bits), .nmi_ack(nmi_ack),
    .irq_pend(irq_pend), .irl_level(irl_level), .nmi_req(nmi_req)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  string tag = "R1";

  // ---------------- behavioural reference model ----------------
  logic [7:0] p1, p2, mf, ml, mprev, mpend;
  int         mrun [8];
  logic [3:0] gf [2];
  logic [3:0] gl [2];
  logic [3:0] glat [2];
  int         grun [2];
  logic       n1, n2, nprev, nreq;

  always @(posedge clk) begin
    if (!rst_n) begin
      p1 = '1; p2 = '1; mf = '1; ml = '1; mprev = '1; mpend = '0;
      for (int i = 0; i < 8; i++) mrun[i] = 0;
      for (int g = 0; g < NG; g++) begin
        gf[g] = '1; gl[g] = '1; glat[g] = '0; grun[g] = 0;
      end
      n1 = 1'b1; n2 = 1'b1; nprev = 1'b1; nreq = 1'b0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        logic src;
        logic cl;
        src = grp_irq_mode[i/4] ? p2[i] : 1'b1;
        cl  = clr_we && clr_bits[i];
        if (irq_edge[i]) begin
          if (mprev[i] && !src) mpend[i] = 1'b1;
          else if (cl)          mpend[i] = 1'b0;
        end else if (hold_off)  mpend[i] = 1'b0;
        else if (!mf[i])        mpend[i] = 1'b1;
        else if (cl)            mpend[i] = 1'b0;
        mprev[i] = src;
        if (src == ml[i]) begin if (mrun[i] < STABLE) mrun[i]++; end
        else mrun[i] = 1;
        ml[i] = src;
        if (src != mf[i] && mrun[i] >= STABLE) mf[i] = src;
      end
      for (int g = 0; g < NG; g++) begin
        logic [3:0] code;
        logic [3:0] lv;
        code = grp_irq_mode[g] ? 4'hF : p2[g*4 +: 4];
        lv   = ~gf[g];
        if (hold_off)                                   glat[g] = '0;
        else if (clr_we && clr_bits[8+g])               glat[g] = '0;
        else if (glat[g] == 0 && lv != 0 && !irl_mask[g]) glat[g] = lv;
        if (code == gl[g]) begin if (grun[g] < STABLE) grun[g]++; end
        else grun[g] = 1;
        gl[g] = code;
        if (code != gf[g] && grun[g] >= STABLE) gf[g] = code;
      end
      p2 = p1; p1 = pin_n;
      if (nprev && !n2) nreq = 1'b1;
      else if (nmi_ack) nreq = 1'b0;
      nprev = n2; n2 = n1; n1 = nmi_n;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] ei;
      logic [7:0] el;
      for (int i = 0; i < 8; i++)
        ei[i] = (irq_edge[i] || !hold_off) ? mpend[i] : ~mf[i];
      for (int g = 0; g < NG; g++)
        el[g*4 +: 4] = hold_off ? (irl_mask[g] ? 4'h0 : ~gf[g]) : glat[g];
      checks += 3;
      if (irq_pend !== ei) begin
        errors++;
        $display("FAIL %s irq_pend act=%h exp=%h t=%0t", tag, irq_pend, ei, $time);
      end
      if (irl_level !== el) begin
        errors++;
        $display("FAIL %s irl_level act=%h exp=%h t=%0t", tag, irl_level, el, $time);
      end
      if (nmi_req !== nreq) begin
        errors++;
        $display("FAIL %s nmi_req act=%b exp=%b t=%0t", tag, nmi_req, nreq, $time);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<=%0d", cyc, 50000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic pulse_clr(input logic [9:0] b);
    clr_we = 1'b1; clr_bits = b;
    tick(1);
    clr_we = 1'b0; clr_bits = '0;
  endtask

  initial begin
    // R1: reset state
    tick(3);
    @(negedge clk);
    chk("R1", {15'd0, nmi_req, irl_level, irq_pend}, 32'd0);
    tick(1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {15'd0, nmi_req, irl_level, irq_pend}, 32'd0);

    // R7 / R2: both groups as encoded level, transparent
    tag = "R7";
    hold_off = 1'b1; grp_irq_mode = 2'b00;
    tick(1);
    pin_n = 8'b1111_1010;
    tick(8); @(negedge clk);
    chk("R7", irl_level, 8'h05);
    chk("R2", irq_pend, 8'h00);

    // R3: two-cycle glitch ignored
    tag = "R3";
    tick(1);
    pin_n = 8'b1111_0000; tick(2);
    pin_n = 8'b1111_1010; tick(8); @(negedge clk);
    chk("R3", irl_level, 8'h05);

    // R10: mask hides transparent level
    tag = "R10";
    tick(1);
    irl_mask = 2'b01;
    @(negedge clk);
    chk("R10", irl_level, 8'h00);
    tick(1);
    irl_mask = 2'b00;

    // R2: group 0 switched to request lines
    tag = "R2";
    grp_irq_mode = 2'b01;
    tick(8); @(negedge clk);
    chk("R2", irl_level, 8'h00);
    chk("R2", irq_pend, 8'h05);

    // R8 / R9: stored level
    tag = "R8";
    tick(1);
    pin_n = 8'hFF; grp_irq_mode = 2'b00;
    tick(8);
    hold_off = 1'b0;
    tick(4);
    pulse_clr(10'h3FF);
    pin_n = 8'b1111_0110;
    tick(8); @(negedge clk);
    chk("R8", irl_level, 8'h09);
    tick(1);
    irl_mask = 2'b01;
    tick(3); @(negedge clk);
    chk("R9", irl_level, 8'h09);
    tick(1);
    pin_n = 8'hFF;
    tick(8); @(negedge clk);
    chk("R8", irl_level, 8'h09);
    tick(1);
    pulse_clr(10'h100);
    @(negedge clk);
    chk("R8", irl_level, 8'h00);
    tick(1);
    tag = "R9";
    pin_n = 8'b1111_1100;
    tick(8); @(negedge clk);
    chk("R9", irl_level, 8'h00);
    tick(1);
    irl_mask = 2'b00;
    tick(2); @(negedge clk);
    chk("R9", irl_level, 8'h03);
    tick(1);
    tag = "R8";
    pulse_clr(10'h100);
    @(negedge clk);
    chk("R8", irl_level, 8'h00);
    tick(1); @(negedge clk);
    chk("R8", irl_level, 8'h03);

    // R5: latched level-sense request lines
    tag = "R5";
    tick(1);
    pin_n = 8'hFF; grp_irq_mode = 2'b11;
    tick(8);
    pulse_clr(10'h3FF);
    tick(2); @(negedge clk);
    chk("R2", irl_level, 8'h00);
    chk("R5", irq_pend, 8'h00);
    tick(1);
    pin_n[2] = 1'b0; tick(6);
    pin_n[2] = 1'b1; tick(8); @(negedge clk);
    chk("R5", irq_pend, 8'h04);
    tick(1);
    pulse_clr(10'h004);
    @(negedge clk);
    chk("R5", irq_pend, 8'h00);

    // R3: short pulse on a level line ignored
    tag = "R3";
    tick(1);
    pin_n[3] = 1'b0; tick(2);
    pin_n[3] = 1'b1; tick(8); @(negedge clk);
    chk("R3", irq_pend, 8'h00);

    // R6 with exact R3 latency
    tag = "R6";
    tick(1);
    hold_off = 1'b1;
    tick(2);
    pin_n[6] = 1'b0;
    tick(4); @(negedge clk);
    chk("R3", irq_pend, 8'h00);
    tick(1); @(negedge clk);
    chk("R3", irq_pend, 8'h40);
    tick(1);
    pulse_clr(10'h040);
    @(negedge clk);
    chk("R6", irq_pend, 8'h40);
    tick(1);
    pin_n[6] = 1'b1;
    tick(6); @(negedge clk);
    chk("R6", irq_pend, 8'h00);

    // R4: edge-sense line
    tag = "R4";
    tick(1);
    irq_edge = 8'h20;
    pin_n[5] = 1'b0; tick(1);
    pin_n[5] = 1'b1; tick(6); @(negedge clk);
    chk("R4", irq_pend, 8'h20);
    tick(1);
    hold_off = 1'b0;
    tick(2); @(negedge clk);
    chk("R4", irq_pend, 8'h20);
    tick(1);
    pulse_clr(10'h020);
    @(negedge clk);
    chk("R4", irq_pend, 8'h00);
    tick(1);
    pin_n[5] = 1'b0; tick(2);
    pulse_clr(10'h020);
    @(negedge clk);
    chk("R4", irq_pend, 8'h20);
    tick(1);
    pin_n[5] = 1'b1;
    pulse_clr(10'h020);
    tick(2);

    // R11: NMI
    tag = "R11";
    nmi_n = 1'b0; tick(1);
    nmi_n = 1'b1; tick(5); @(negedge clk);
    chk("R11", nmi_req, 1'b1);
    tick(1);
    nmi_ack = 1'b1; tick(1); nmi_ack = 1'b0;
    @(negedge clk);
    chk("R11", nmi_req, 1'b0);
    tick(1);
    nmi_n = 1'b0; tick(6); @(negedge clk);
    chk("R11", nmi_req, 1'b1);
    tick(1);
    nmi_ack = 1'b1; tick(1); nmi_ack = 1'b0;
    tick(5); @(negedge clk);
    chk("R11", nmi_req, 1'b0);
    tick(1);
    nmi_n = 1'b1;
    irq_edge = '0;

    // random mix, reference model compared every clock
    tag = "R5";
    for (int n = 0; n < 3000; n++) begin
      for (int b = 0; b < 8; b++)
        if ($urandom % 5 == 0) pin_n[b] = ~pin_n[b];
      if ($urandom % 64 == 0)  grp_irq_mode = 2'($urandom);
      if ($urandom % 128 == 0) hold_off = ~hold_off;
      if ($urandom % 128 == 0) irq_edge = 8'($urandom);
      if ($urandom % 16 == 0)  irl_mask = 2'($urandom);
      clr_we   = ($urandom % 8 == 0);
      clr_bits = 10'($urandom);
      if ($urandom % 8 == 0) nmi_n = ~nmi_n;
      nmi_ack = ($urandom % 8 == 0);
      tick(1);
    end
    clr_we = 1'b0; nmi_ack = 1'b0;
    tick(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule